// File: doc/BRIEF.md
# Stream Buffer with Data-Request Flag

This block is the byte queue that sits between a serial data port and the audio decoder that consumes the stream. The port's deserialiser presents each completed byte with a one-cycle write strobe. The consumer pops bytes with a read strobe and reads the oldest byte from a first-word-fall-through output.

A single registered request output tells the host whether it may start another burst. The output is high only when the queue has room for a full burst and no register command is being executed. A host can therefore send one fixed-size burst after each check of the pin, without polling an occupancy count.

The request can drop at any cycle, including in the middle of a byte. A byte that completes after the drop is still stored whenever physical space remains. Only a write into a completely full queue is lost, and such a loss is recorded in a sticky overflow flag.

Top module: `stream_buffer`

## Requirements
- R1: Bytes leave the queue in the order they were accepted. `rd_data` shows the oldest stored byte whenever `empty` is low, and a read strobe removes that byte at the clock edge.
- R2: `empty` is high exactly when the queue holds no bytes, as seen after each clock edge.
- R3: After each edge, `data_req` is high when the free space is at least `BURST` bytes and `cmd_busy` was low at that edge. Free space is `DEPTH` minus the occupancy after that edge.
- R4: `data_req` is low after any edge that leaves fewer than `BURST` free bytes.
- R5: `data_req` is low after every edge at which `cmd_busy` was sampled high, whatever the free space.
- R6: A write strobe is accepted whenever the queue is not full, whether `data_req` is high or low.
- R7: A write and a read in the same cycle on a non-empty queue both take effect and leave the occupancy unchanged. This includes a queue that is completely full.
- R8: A write strobe on a completely full queue with no read in the same cycle is dropped. It sets `overflow`, which then stays high until reset.
- R9: A read strobe on an empty queue has no effect. The next byte written is the next byte read.
- R10: While `rst_n` is low at a clock edge, the queue empties, `overflow` clears and `data_req` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Byte write strobe from the serial port |
| wr_data | input | DATA_W | Byte to store |
| rd_en | input | 1 | Pop strobe from the consumer |
| cmd_busy | input | 1 | High while a register command executes |
| rd_data | output | DATA_W | Oldest stored byte, valid while `empty` is low |
| empty | output | 1 | Queue holds no bytes |
| data_req | output | 1 | Host may send another burst |
| overflow | output | 1 | Sticky flag, set by a dropped write |

## Verification
The bench builds the block with `DEPTH` = 64 and `BURST` = 8 instead of 2048 and 32. With these values the full queue, the request threshold and write-at-full are all reached within a few dozen cycles. The random phase can therefore cross the threshold and the full boundary many times in both directions. Because the pointers are narrower, their wrap-around is also exercised repeatedly.

// File: rtl/sbuf_pkg.sv
// Package: shared types and helpers for the stream buffer.
// Assumes: depth and occupancy fit in 32 bits.
package sbuf_pkg;

    // Kind of pointer movement in one cycle
    typedef enum logic [1:0] {
        SB_IDLE = 2'b00,
        SB_POP  = 2'b01,
        SB_PUSH = 2'b10,
        SB_BOTH = 2'b11
    } sbuf_op_e;

    // Free byte slots for a queue of the given depth and occupancy
    function automatic int unsigned free_slots(input int unsigned depth,
                                               input int unsigned used);
        return depth - used;
    endfunction

endpackage

// File: rtl/sbuf_occupancy.sv
// Module: sbuf_occupancy
// Decides which strobes are honoured and keeps the pointers, the occupancy
// count and the sticky overflow flag.
// Assumes: DEPTH is a power of two, so the pointers wrap naturally.
module sbuf_occupancy
    import sbuf_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    output logic             push,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] free_cnt,
    output logic [CNT_W-1:0] free_next,
    output logic             empty,
    output logic             overflow
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    generate
        if ((1 << PTR_W) != DEPTH) begin : g_bad_depth
            $error("sbuf_occupancy: DEPTH must be a power of two");
        end
    endgenerate

    logic [CNT_W-1:0] used_q;
    logic [CNT_W-1:0] used_d;
    logic             full;
    logic             pop;
    sbuf_op_e         op;

    // Honour strobes: pop when data exists; push when room exists or a pop frees a slot
    always_comb begin
        full = (used_q == FULL_CNT);
        pop  = rd_en && (used_q != '0);
        push = wr_en && (!full || pop);
        op   = sbuf_op_e'({push, pop});
    end

    // Next occupancy from the honoured strobes
    always_comb begin
        case (op)
            SB_PUSH: used_d = used_q + 1'b1;
            SB_POP:  used_d = used_q - 1'b1;
            default: used_d = used_q;
        endcase
    end

    // Free counts now and after the coming edge
    always_comb begin
        free_cnt  = CNT_W'(free_slots(DEPTH, 32'(used_q)));
        free_next = CNT_W'(free_slots(DEPTH, 32'(used_d)));
        empty     = (used_q == '0);
    end

    // Pointer, occupancy and overflow registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used_q   <= '0;
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            overflow <= 1'b0;
        end else begin
            used_q <= used_d;
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            if (wr_en && !push) overflow <= 1'b1;
        end
    end

    // R6: a write into a non-full queue without a read raises occupancy by one
    assert_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && (used_q != FULL_CNT)) |=> (used_q == $past(used_q) + 1'b1));

    // R7: simultaneous write and read on a non-empty queue keeps occupancy
    assert_mixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && (used_q != '0)) |=> $stable(used_q));

    // R8: write at full without a read is dropped and flags overflow
    assert_drop_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && (used_q == FULL_CNT)) |=> (overflow && $stable(wr_ptr)));

    // R8: overflow stays set until reset
    assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R9: a read on an empty queue moves nothing
    assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && (used_q == '0)) |=> (empty && $stable(rd_ptr)));

endmodule

// File: rtl/sbuf_store.sv
// Module: sbuf_store
// Byte storage: one write port and an asynchronous read of the head slot.
// Assumes: the caller writes only honoured bytes; contents are not reset.
module sbuf_store #(
    parameter int DEPTH  = 2048,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              push,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_ptr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Store an accepted byte at the write pointer
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wr_data;
    end

    // Present the oldest byte
    assign rd_data = mem[rd_ptr];

endmodule

// File: rtl/sbuf_request.sv
// Module: sbuf_request
// Registered data-request flag: headroom for a burst and no command running.
// Assumes: cmd_busy is synchronous to clk.
module sbuf_request #(
    parameter int DEPTH = 2048,
    parameter int BURST = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_busy,
    input  logic [CNT_W-1:0] free_next,
    input  logic [CNT_W-1:0] free_cnt,
    output logic             data_req
);

    localparam logic [CNT_W-1:0] BURST_CNT = CNT_W'(BURST);

    generate
        if (BURST > DEPTH || BURST < 1) begin : g_bad_burst
            $error("sbuf_request: BURST must lie in 1..DEPTH");
        end
    endgenerate

    // Request register, high after reset
    always_ff @(posedge clk) begin
        if (!rst_n) data_req <= 1'b1;
        else        data_req <= (free_next >= BURST_CNT) && !cmd_busy;
    end

    // R4: request is never high without burst headroom
    assert_req_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
        data_req |-> (free_cnt >= BURST_CNT));

    // R5: a command in progress holds the request low after the edge
    assert_req_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_busy |=> !data_req);

endmodule

// File: rtl/stream_buffer.sv
// Module: stream_buffer
// Byte queue between the serial data port and the stream consumer, with a
// burst-sized data-request output to the host.
// Assumes: all inputs are synchronous to clk; DEPTH is a power of two.
module stream_buffer #(
    parameter int DEPTH  = 2048,
    parameter int BURST  = 32,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              cmd_busy,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              data_req,
    output logic              overflow
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             push;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] free_cnt;
    logic [CNT_W-1:0] free_next;

    sbuf_occupancy #(.DEPTH(DEPTH)) u_occ (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .push      (push),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .free_cnt  (free_cnt),
        .free_next (free_next),
        .empty     (empty),
        .overflow  (overflow)
    );

    sbuf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .push    (push),
        .wr_ptr  (wr_ptr),
        .wr_data (wr_data),
        .rd_ptr  (rd_ptr),
        .rd_data (rd_data)
    );

    sbuf_request #(.DEPTH(DEPTH), .BURST(BURST)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_busy  (cmd_busy),
        .free_next (free_next),
        .free_cnt  (free_cnt),
        .data_req  (data_req)
    );

    // R2: an empty queue offers the full depth as free space
    assert_empty_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (free_cnt == CNT_W'(DEPTH)));

endmodule

// File: tb/stream_buffer_bench.sv
// Bench for stream_buffer: directed corners plus seeded random traffic,
// compared against a queue model kept in the bench.
module stream_buffer_bench;

    localparam int DEPTH  = 64;
    localparam int BURST  = 8;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              rd_en = 1'b0;
    logic              cmd_busy = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic              empty;
    logic              data_req;
    logic              overflow;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [DATA_W-1:0] q[$];
    bit m_ovf = 1'b0;
    bit m_req = 1'b1;

    always #2 clk = ~clk;

    stream_buffer #(.DEPTH(DEPTH), .BURST(BURST), .DATA_W(DATA_W)) u_stream_buffer (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .cmd_busy (cmd_busy),
        .rd_data  (rd_data),
        .empty    (empty),
        .data_req (data_req),
        .overflow (overflow)
    );

    function automatic bit exp_req(int used, bit busy);
        return ((DEPTH - used) >= BURST) && !busy;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        q.delete();
        m_ovf = 1'b0;
        m_req = 1'b1;
    endtask

    task automatic verify();
        chk("R2 empty flag", int'(empty), int'(q.size() == 0));
        chk("R3 R4 R5 request flag", int'(data_req), int'(m_req));
        chk("R8 overflow flag", int'(overflow), int'(m_ovf));
        if (q.size() > 0) chk("R1 head byte", int'(rd_data), int'(q[0]));
    endtask

    // Drive one cycle of strobes, advance the model at the edge, check at negedge
    task automatic step(bit w, logic [DATA_W-1:0] d, bit r, bit b);
        bit pop;
        bit push;
        wr_en = w; wr_data = d; rd_en = r; cmd_busy = b;
        @(posedge clk);
        pop  = r && (q.size() > 0);
        push = w && ((q.size() < DEPTH) || pop);
        if (w && !push) m_ovf = 1'b1;
        if (pop) void'(q.pop_front());
        if (push) q.push_back(d);
        m_req = exp_req(q.size(), b);
        @(negedge clk);
        verify();
    endtask

    task automatic do_reset();
        wr_en = 0; rd_en = 0; cmd_busy = 0;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        model_reset();
        @(negedge clk);
        chk("R10 empty after reset", int'(empty), 1);
        chk("R10 overflow after reset", int'(overflow), 0);
        chk("R10 request after reset", int'(data_req), 1);
        rst_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // Fill to full; request drops once fewer than BURST slots remain
        for (int i = 0; i < DEPTH; i++) begin
            step(1'b1, DATA_W'(i), 1'b0, 1'b0);
            if (i == DEPTH - BURST - 1) chk("R3 request at exact headroom", int'(data_req), 1);
            if (i == DEPTH - BURST)     chk("R4 request below headroom", int'(data_req), 0);
        end
        chk("R6 bytes taken while request low", int'(empty), 0);

        // Write at full with no read is dropped
        step(1'b1, 8'hEE, 1'b0, 1'b0);
        chk("R8 overflow set by dropped write", int'(overflow), 1);
        chk("R8 head unchanged by dropped write", int'(rd_data), 0);

        // Simultaneous write and read at full
        step(1'b1, 8'h55, 1'b1, 1'b0);
        chk("R7 head after mixed op at full", int'(rd_data), 1);

        // Drain completely; last byte is the one written during the mixed op
        for (int i = 0; i < DEPTH - 1; i++) step(1'b0, '0, 1'b1, 1'b0);
        chk("R7 last byte kept", int'(rd_data), 8'h55);
        step(1'b0, '0, 1'b1, 1'b0);
        chk("R2 empty after drain", int'(empty), 1);
        chk("R8 overflow still sticky", int'(overflow), 1);

        // Read on empty has no effect
        step(1'b0, '0, 1'b1, 1'b0);
        step(1'b0, '0, 1'b1, 1'b0);
        step(1'b1, 8'hA5, 1'b0, 1'b0);
        chk("R9 next byte after empty reads", int'(rd_data), 8'hA5);
        step(1'b0, '0, 1'b1, 1'b0);
        chk("R9 queue empty again", int'(empty), 1);

        // Command busy holds request low, and a write during it still lands
        step(1'b0, '0, 1'b0, 1'b1);
        chk("R5 request low while busy", int'(data_req), 0);
        step(1'b1, 8'h3C, 1'b0, 1'b1);
        chk("R6 write accepted during command", int'(rd_data), 8'h3C);
        step(1'b0, '0, 1'b0, 1'b0);
        chk("R5 request back after command", int'(data_req), 1);

        // Random traffic with segments biased toward filling or draining
        for (int i = 0; i < 4000; i++) begin
            bit fill = ((i / 300) % 2) == 0;
            bit w = fill ? (($urandom % 8) != 0) : (($urandom % 8) < 3);
            bit r = fill ? (($urandom % 8) < 3) : (($urandom % 8) != 0);
            bit b = ($urandom % 10) == 0;
            step(w, DATA_W'($urandom), r, b);
        end

        // Reset from a loaded, overflowed state
        for (int i = 0; i < DEPTH + 2; i++) step(1'b1, DATA_W'(i), 1'b0, 1'b0);
        do_reset();
        step(1'b0, '0, 1'b0, 1'b0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=timeout expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule